// File: doc/BRIEF.md
# SPI Serial EEPROM Host Sequencer

This block sits on the host side of a byte-wide SPI serial EEPROM. It takes one request at a time from a small request interface and turns it into SPI transactions. A request is a write or a read, with a start address and a byte count. The block drives serial clock, chip select and the host-to-memory data line, and it samples the memory-to-host data line. It runs in SPI mode 0: the clock idles low, the host changes its output while the clock is low, and it samples input on the rising edge.

For a write, the block breaks the request into pieces that never cross a page. Each piece goes out as three transactions. First comes a one-byte write-enable transaction. Next comes the write transaction itself. Last, the status register is read repeatedly until the busy flag clears. A read request is sent as a single transaction that streams out as many bytes as were asked for. Between any two transactions, chip select stays high for a programmable number of clocks. If the busy flag never clears, a poll limit ends the request with an error flag.

Top module: `spi_eeprom_host`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done, err and rd_valid are 0.
- R2: spi_sck is 0 whenever spi_cs_n is 1 and whenever chip select falls. spi_mosi changes only while spi_sck is low. All bytes go most significant bit first. spi_miso is sampled on the rising spi_sck edge.
- R3: Every write transaction (first byte 0x02, then a 16-bit address high byte first, then data) is preceded by its own transaction consisting of exactly the byte 0x06. The data bytes of one write transaction all lie in one page of 2^PAGE_W bytes, so they share every address bit above bit PAGE_W-1. A longer request is split into consecutive page-aligned pieces.
- R4: Each transaction contains a whole number of bytes. In a write, chip select rises right after the last bit of the final data byte.
- R5: After each write transaction, the block reads status (0x05 followed by one dummy byte). It repeats this until status bit 0 reads 0. No other transaction starts while that bit is 1.
- R6: A read request sends 0x03 and the 16-bit address, then clocks in exactly req_len bytes. Each byte is presented on rd_data with a one-cycle rd_valid pulse, in ascending address order, and the address wraps from the top of memory to 0.
- R7: spi_cs_n stays high for at least GAP_CLKS clock cycles between transactions, including before the first transaction of a request.
- R8: If status bit 0 reads 1 in POLL_MAX consecutive status reads, err is set and the request ends with done. No further transaction starts. err clears when the next request is accepted.
- R9: A request with req_len 0 ends with a done pulse in the cycle after acceptance and causes no chip select activity.
- R10: Write data is taken from wdata in order. A one-cycle wdata_pop pulse marks each byte taken, so there are exactly req_len pulses per write request.
- R11: req_ready is 1 only while idle, and each request produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | First byte address |
| req_len | input | LEN_W | Number of bytes |
| wdata | input | 8 | Next write data byte |
| wdata_pop | output | 1 | Pulse: the byte on wdata was taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: request finished |
| err | output | 1 | Busy-poll limit reached on the last request |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Host-to-memory serial data |
| spi_miso | input | 1 | Memory-to-host serial data |

## Verification
The bench builds the block with CLK_DIV 2, GAP_CLKS 3, POLL_MAX 8, a 10-bit address, 16-byte pages and an 8-bit length. The short clock divider and the short busy time of the memory model keep multi-page writes within the cycle budget. With a 10-bit address, the end of memory can be reached, so a write and a 255-byte read both wrap through address 0. A poll limit of 8 lets a model whose busy flag never clears reach the error path quickly. The memory model checks transaction framing, the write-enable order, page containment and the select gap on every transaction.

// File: rtl/smseq_pkg.sv
package smseq_pkg;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_WENA   = 8'h06;
    localparam logic [7:0] OP_STATUS = 8'h05;

    typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_XFER} st_e;
    typedef enum logic [1:0] {K_WENA, K_WRITE, K_POLL, K_READ} kind_e;
    typedef enum logic [2:0] {N_WENA, N_WRITE, N_POLL, N_READ, N_FIN} nxt_e;
    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;
endpackage

// File: rtl/smseq_shift.sv
module smseq_shift
    import smseq_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        ph_e           ph;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          sck;
        logic          mosi;
        logic          done;
    } eng_t;

    eng_t q, d;
    logic half_end;

    // half-period terminal count; a divide of one needs no counter compare
    generate
        if (CLK_DIV == 1) begin : g_div1
            assign half_end = 1'b1;
        end else begin : g_divn
            assign half_end = (q.cnt == CW'(CLK_DIV - 1));
        end
    endgenerate

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph   = PH_LO;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.sh   = tx;
                    d.mosi = tx[7];
                end
            end
            PH_LO: begin
                if (half_end) begin
                    d.cnt = '0;
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                    d.ph  = PH_HI;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_HI: begin
                if (half_end) begin
                    d.cnt = '0;
                    d.sck = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.mosi = q.sh[6];
                        d.ph   = PH_LO;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign rx   = q.rx;
    assign sck  = q.sck;
    assign mosi = q.mosi;

    // R2: output data holds steady across every high clock phase
    a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sck && $past(q.sck)) |-> $stable(q.mosi));
endmodule

// File: rtl/smseq_page.sv
module smseq_page #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 8,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  chunk
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int W    = (LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1;

    logic [W-1:0] room;
    logic [W-1:0] remx;
    logic [W-1:0] pick;

    always_comb begin
        room  = W'(PAGE) - W'(addr[PAGE_W-1:0]);
        remx  = W'(rem);
        pick  = (remx < room) ? remx : room;
        chunk = LEN_W'(pick);
        // R3: a piece never runs past the end of its page
        a_r3_piece_in_page: assert (rem == '0 ||
            (chunk != '0 && (W'(addr[PAGE_W-1:0]) + W'(chunk)) <= W'(PAGE)));
    end
endmodule

// File: rtl/spi_eeprom_host.sv
module spi_eeprom_host
    import smseq_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int LEN_W    = 8,
    parameter int PAGE_W   = 4,
    parameter int CLK_DIV  = 4,
    parameter int GAP_CLKS = 4,
    parameter int POLL_MAX = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wdata,
    output logic              wdata_pop,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              err,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int IDX_W  = LEN_W + 2;
    localparam int GAP_W  = $clog2(GAP_CLKS + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    typedef struct packed {
        st_e               st;
        kind_e             kind;
        nxt_e              nxt;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  chunk;
        logic [IDX_W-1:0]  bidx;
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] polls;
        logic              cs_n;
        logic              start;
        logic [7:0]        tx;
        logic              pop;
        logic              rd_valid;
        logic [7:0]        rd_data;
        logic              done;
        logic              err;
    } host_t;

    host_t q, d;

    logic             eng_done;
    logic [7:0]       eng_rx;
    logic [LEN_W-1:0] piece;
    logic             fin;
    nxt_e             fin_to;
    logic [IDX_W-1:0] nb;
    logic [15:0]      a16;

    smseq_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (q.start),
        .tx    (q.tx),
        .miso  (spi_miso),
        .done  (eng_done),
        .rx    (eng_rx),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

    smseq_page #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_page (
        .addr  (q.addr),
        .rem   (q.rem),
        .chunk (piece)
    );

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.pop      = 1'b0;
        d.rd_valid = 1'b0;
        d.done     = 1'b0;
        fin        = 1'b0;
        fin_to     = N_FIN;
        nb         = q.bidx + 1'b1;
        a16        = 16'(q.addr);
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.rem  = req_len;
                    d.err  = 1'b0;
                    if (req_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st  = ST_GAP;
                        d.gap = '0;
                        d.nxt = req_write ? N_WENA : N_READ;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap >= GAP_W'(GAP_CLKS - 1)) begin
                    if (q.nxt == N_FIN) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st    = ST_XFER;
                        d.cs_n  = 1'b0;
                        d.start = 1'b1;
                        d.bidx  = '0;
                        case (q.nxt)
                            N_WENA:  begin d.kind = K_WENA;  d.tx = OP_WENA;   end
                            N_WRITE: begin d.kind = K_WRITE; d.tx = OP_WRITE; d.chunk = piece; end
                            N_POLL:  begin d.kind = K_POLL;  d.tx = OP_STATUS; end
                            default: begin d.kind = K_READ;  d.tx = OP_READ;   end
                        endcase
                    end
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            ST_XFER: begin
                if (eng_done) begin
                    d.bidx = nb;
                    case (q.kind)
                        K_WENA: begin
                            fin    = 1'b1;
                            fin_to = N_WRITE;
                        end
                        K_WRITE: begin
                            if (nb < IDX_W'(3)) begin
                                d.tx    = (nb == IDX_W'(1)) ? a16[15:8] : a16[7:0];
                                d.start = 1'b1;
                            end else if ((nb - IDX_W'(3)) < IDX_W'(q.chunk)) begin
                                d.tx    = wdata;
                                d.pop   = 1'b1;
                                d.start = 1'b1;
                            end else begin
                                d.addr  = q.addr + ADDR_W'(q.chunk);
                                d.rem   = q.rem - q.chunk;
                                d.polls = '0;
                                fin     = 1'b1;
                                fin_to  = N_POLL;
                            end
                        end
                        K_POLL: begin
                            if (nb == IDX_W'(1)) begin
                                d.tx    = 8'h00;
                                d.start = 1'b1;
                            end else begin
                                fin = 1'b1;
                                if (!eng_rx[0]) begin
                                    fin_to = (q.rem == '0) ? N_FIN : N_WENA;
                                end else if (q.polls == POLL_W'(POLL_MAX - 1)) begin
                                    d.err  = 1'b1;
                                    fin_to = N_FIN;
                                end else begin
                                    d.polls = q.polls + 1'b1;
                                    fin_to  = N_POLL;
                                end
                            end
                        end
                        default: begin
                            if (q.bidx >= IDX_W'(3)) begin
                                d.rd_valid = 1'b1;
                                d.rd_data  = eng_rx;
                            end
                            if (nb < IDX_W'(3)) begin
                                d.tx    = (nb == IDX_W'(1)) ? a16[15:8] : a16[7:0];
                                d.start = 1'b1;
                            end else if ((nb - IDX_W'(3)) < IDX_W'(q.rem)) begin
                                d.tx    = 8'h00;
                                d.start = 1'b1;
                            end else begin
                                fin    = 1'b1;
                                fin_to = N_FIN;
                            end
                        end
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (fin) begin
            d.cs_n = 1'b1;
            d.st   = ST_GAP;
            d.gap  = '0;
            d.nxt  = fin_to;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_WENA;
            q.nxt  <= N_FIN;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign wdata_pop = q.pop;
    assign rd_data   = q.rd_data;
    assign rd_valid  = q.rd_valid;
    assign done      = q.done;
    assign err       = q.err;
    assign spi_cs_n  = q.cs_n;

    // run length of deselected cycles, used to check the select gap
    logic [GAP_W:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (!spi_cs_n) begin
            hi_run <= '0;
        end else if (hi_run < (GAP_W+1)'(GAP_CLKS)) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R7: chip select falls only after a full gap
    a_r7_select_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(spi_cs_n)) |-> (hi_run >= (GAP_W+1)'(GAP_CLKS)));
    // R2: serial clock is low while deselected
    a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R11: idle only with the memory deselected
    a_r11_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);
    // R8: after a poll timeout no transaction runs
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> spi_cs_n);
    // R10: write data is only taken inside a selected transaction
    a_r10_pop_selected: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_pop |-> !spi_cs_n);
endmodule

// File: tb/spi_eeprom_host_tb.sv
module spi_eeprom_host_tb;
    localparam int P_DIV  = 2;
    localparam int P_GAP  = 3;
    localparam int P_POLL = 8;
    localparam int BUSY_T = 150;
    localparam int MSZ    = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_len = '0;
    logic [7:0] wdata;
    logic       wdata_pop;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       done;
    logic       err;
    logic       spi_cs_n;
    logic       spi_sck;
    logic       spi_mosi;
    logic       miso = 1'b0;

    always #5 clk = ~clk;

    spi_eeprom_host #(
        .ADDR_W(10), .LEN_W(8), .PAGE_W(4),
        .CLK_DIV(P_DIV), .GAP_CLKS(P_GAP), .POLL_MAX(P_POLL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wdata(wdata), .wdata_pop(wdata_pop),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(miso)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] exp_mem [0:MSZ-1];
    logic [7:0] mem     [0:MSZ-1];
    logic [7:0] wbuf    [0:63];
    int         widx = 0;
    int         n_done = 0;
    int         n_req = 0;

    assign wdata = wbuf[widx[5:0]];

    always @(negedge clk) begin
        if (wdata_pop) widx++;
        if (done) n_done++;
    end

    // ---------------- memory model, evaluated between clock edges -------------
    logic       sck_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;
    int         bits = 0, hi_cnt = 0, cs_falls = 0, busy_t = 0;
    logic [7:0] shin = '0, opc = '0, ah = '0, cur = '0, stv;
    int         ra = 0, pend_base = 0, pend_off = 0, pend_n = 0, pos;
    bit         wel = 0, stuck = 0, si_bad = 0, page_err = 0, rd_busy = 0, wipm;
    logic [7:0] pend [0:15];
    bit         pv   [0:15];

    always @(negedge clk) begin
        if (rst_n) begin
            wipm = (busy_t != 0);
            if (!spi_cs_n && cs_p) begin
                chk(hi_cnt >= P_GAP, "R7 select gap", hi_cnt, P_GAP);
                chk(!spi_sck, "R2 clock low at select", spi_sck, 0);
                cs_falls++;
                bits = 0; si_bad = 0; opc = '0; pend_n = 0; page_err = 0; rd_busy = 0;
                for (int j = 0; j < 16; j++) pv[j] = 0;
            end
            if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
            if (!spi_cs_n && spi_sck && !sck_p) begin
                shin = {shin[6:0], spi_mosi};
                bits++;
                if (bits % 8 == 0) begin
                    if (bits == 8) opc = shin;
                    else if (bits == 16) ah = shin;
                    else if (bits == 24) begin
                        ra = {ah, shin} % MSZ;
                        pend_base = ra - (ra % 16);
                        pend_off = ra % 16;
                    end else if (opc == 8'h02) begin
                        pos = pend_off + pend_n;
                        if (pos >= 16) page_err = 1;
                        pend[pos % 16] = shin;
                        pv[pos % 16] = 1;
                        pend_n++;
                    end
                end
            end
            if (!spi_cs_n && spi_sck && sck_p && spi_mosi != mosi_p) si_bad = 1;
            if (!spi_cs_n && !spi_sck && sck_p) begin
                if (opc == 8'h03 && bits >= 24) begin
                    pos = (bits - 24) % 8;
                    if (pos == 0) begin
                        if (wipm) rd_busy = 1;
                        cur = wipm ? 8'hEE : mem[ra];
                        ra = (ra + 1) % MSZ;
                    end
                    miso = cur[7-pos];
                end else if (opc == 8'h05 && bits >= 8) begin
                    stv = {6'b0, wel, wipm || stuck};
                    miso = stv[7 - ((bits - 8) % 8)];
                end
            end
            if (spi_cs_n && !cs_p) begin
                chk(bits % 8 == 0, "R4 whole bytes", bits % 8, 0);
                chk(!si_bad, "R2 data steady while clock high", si_bad, 0);
                chk(opc == 8'h02 || opc == 8'h03 || opc == 8'h05 || opc == 8'h06,
                    "R3/R5/R6 command code", opc, 0);
                if (opc == 8'h06) begin
                    chk(bits == 8, "R3 enable sent alone", bits, 8);
                    if (bits == 8 && !wipm) wel = 1;
                end else if (opc == 8'h02) begin
                    chk(!wipm, "R5 write while busy", wipm, 0);
                    chk(wel, "R3 enable before write", wel, 1);
                    chk(!page_err, "R3 single page", pend_n, 16 - pend_off);
                    chk(pend_n >= 1, "R4 data present", pend_n, 1);
                    if (wel && !wipm && pend_n >= 1) begin
                        for (int j = 0; j < 16; j++)
                            if (pv[j]) mem[pend_base + j] = pend[j];
                        busy_t = BUSY_T;
                        wel = 0;
                    end
                end else if (opc == 8'h03) begin
                    chk(!rd_busy, "R5 read while busy", rd_busy, 0);
                end
            end
            if (busy_t > 0) busy_t--;
        end
        sck_p = spi_sck; cs_p = spi_cs_n; mosi_p = spi_mosi;
    end

    // ---------------- request tasks -------------------------------------------
    task automatic issue(input bit wr, input int a, input int l);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 10'(a); req_len = 8'(l);
        @(negedge clk);
        req_valid = 1'b0;
        n_req++;
        if (l != 0) chk(!req_ready, "R11 not ready while busy", req_ready, 0);
    endtask

    task automatic do_write(input int a, input int l);
        for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
        widx = 0;
        issue(1'b1, a, l);
        while (!done) @(negedge clk);
        chk(widx == l, "R10 bytes taken", widx, l);
        for (int i = 0; i < l; i++) exp_mem[(a + i) % MSZ] = wbuf[i];
    endtask

    task automatic do_read(input int a, input int l);
        int k;
        k = 0;
        issue(1'b0, a, l);
        forever begin
            if (rd_valid) begin
                chk(rd_data == exp_mem[(a + k) % MSZ], "R6 read data",
                    rd_data, exp_mem[(a + k) % MSZ]);
                k++;
            end
            if (done) break;
            @(negedge clk);
        end
        chk(k == l, "R6 byte count", k, l);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int f0, a, l;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < MSZ; i++) begin
            exp_mem[i] = 8'((i * 37 + 5) ^ (i >> 3));
            mem[i] = exp_mem[i];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 select idle", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 clock idle", spi_sck, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(!done && !err && !rd_valid, "R1 pulses low", {done, err, rd_valid}, 0);

        do_read(10'h010, 5);                 // R6 untouched content
        do_write(10'h00C, 10);               // R3 crosses a page, two pieces
        do_read(10'h00A, 14);
        do_write(10'h3F8, 16);               // R3/R6 piece wraps through address 0
        do_read(10'h3F6, 20);
        do_write(10'h040, 40);               // R3 split into 16, 16, 8
        do_read(10'h040, 40);

        f0 = cs_falls;                       // R9 zero length
        issue(1'b1, 10'h123, 0);
        chk(done == 1'b1, "R9 immediate done", done, 1);
        repeat (20) @(negedge clk);
        chk(cs_falls == f0, "R9 no select", cs_falls, f0);

        for (int r = 0; r < 14; r++) begin
            a = int'($urandom % MSZ);
            l = 1 + int'($urandom % 24);
            if ($urandom % 3 != 0) begin
                do_write(a, l);
                do_read(a, l);
            end else begin
                do_read(a, l);
            end
        end

        stuck = 1;                           // R8 busy flag never clears
        do_write(10'h100, 4);
        chk(err == 1'b1, "R8 error flag", err, 1);
        f0 = cs_falls;
        repeat (200) @(negedge clk);
        chk(cs_falls == f0, "R8 no traffic after error", cs_falls, f0);
        stuck = 0;
        do_read(10'h100, 4);
        chk(err == 1'b0, "R8 error cleared", err, 0);

        do_read(10'h3C0, 255);               // R6 long read wrapping
        repeat (10) @(negedge clk);
        chk(n_done == n_req, "R11 one done per request", n_done, n_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule